// File: doc/BRIEF.md
# Auxiliary Regulator Fault Hiccup Controller

This block supervises an on-chip auxiliary regulator through digital status flags: current limit, undervoltage and overload. A current limit must persist for a programmable number of reference-clock cycles before it counts as a fault. A qualified current limit switches the regulator off for a fixed off-time. After the off-time the regulator restarts through a timed soft-start window. If the limit is still present, the block trips again and the off/retry cycle repeats.

The block also selects the regulator's input source. Either an automatic selector decides, or an override with an explicit choice between the adapter input and the battery. A sticky status bit records overload events and hiccup trips. A stop request goes either to the charging supervisor or to the power-output (OTG) supervisor, depending on the operating mode. Each mode has its own ignore bit, which lets that mode run through the fault. All intervals are parameters counted on one reference clock. The defaults assume a 1 MHz clock: 90 cycles of persistence, 250 cycles of soft-start and 100000 cycles of off-time.

Top module: `reg_hiccup_ctrl`

## Requirements
- R1: After reset, the regulator enable, soft-start flag, off-time flag, sticky fault bit, both stop requests and the switching-stop output are all 0.
- R2: When the enable request rises from the idle state, the regulator enable goes high one cycle later. The soft-start flag is high for exactly SS_CYC cycles and then falls while the regulator enable stays high.
- R3: A current-limit flag sampled high on ILIM_CYC consecutive clock edges while the regulator is enabled drives the regulator enable low and raises the off-time flag. A burst one edge shorter causes no trip.
- R4: The off-time flag stays high for exactly OFF_CYC cycles, and the block then re-enters soft-start. If the current limit is still present, the block trips again after ILIM_CYC more edges.
- R5: Mode code 2'b01 is charge, 2'b10 is OTG and 2'b00 is high-impedance. A fault in charge mode raises only the charge stop request, and a fault in OTG mode raises only the OTG reset request. Either request also raises the switching-stop output. Requests are registered and follow the fault condition by one cycle. High-impedance mode raises no request.
- R6: When the ignore bit of the active mode is 1, no request is raised for either fault, and the off/retry cycle still runs. The ignore bit of the inactive mode has no effect.
- R7: Undervoltage counts as a fault only once soft-start has ended. Undervoltage during soft-start raises no request.
- R8: The sticky fault bit is set one cycle after an overload or during off-time. It holds until the clear input is high while no such fault is present.
- R9: The source output (1 = battery, 0 = adapter input) follows the automatic selector when the override is 0, and follows the select input when the override is 1.
- R10: Dropping the enable request returns the block to idle on the next edge from any state. All three regulator flags then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all timers |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Regulator enable request |
| ilim_i | input | 1 | Current-limit comparator flag |
| uv_i | input | 1 | Undervoltage comparator flag |
| ovl_i | input | 1 | Overload / out-of-spec flag |
| sticky_clr_i | input | 1 | Clear request for the sticky fault bit |
| mode_i | input | 2 | Operating mode: 00 high-impedance, 01 charge, 10 OTG |
| ign_chg_i | input | 1 | Ignore regulator faults in charge mode |
| ign_otg_i | input | 1 | Ignore regulator faults in OTG mode |
| src_ovr_i | input | 1 | Source selection override |
| src_sel_i | input | 1 | Forced source: 0 adapter input, 1 battery |
| auto_src_i | input | 1 | Source chosen by the automatic selector |
| reg_en_o | output | 1 | Regulator enable |
| softstart_o | output | 1 | Soft-start window active |
| hiccup_wait_o | output | 1 | Off-time active; regulator not in regulation |
| fault_sticky_o | output | 1 | Sticky fault status |
| chg_fault_req_o | output | 1 | Stop request to the charge supervisor |
| otg_rst_req_o | output | 1 | Reset request to the OTG supervisor |
| sw_stop_o | output | 1 | Converter switching stop |
| src_vbat_o | output | 1 | Selected input source: 1 battery, 0 adapter |

## Verification
If the persistence counter does not clear between bursts, short current-limit bursts trip the block. This shows on the off-time flag within ILIM_CYC edges of the offending burst. A phase timer with the wrong terminal count changes the measured width of the soft-start or off-time flag by whole cycles, within the first hiccup period. A wrong mode decode or ignore gate puts a request on the wrong supervisor output one cycle after the fault. A sticky bit that clears too early reads 0 on the cycle after a clear issued while overload is held.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SOFT = 2'd1,
    SEQ_RUN  = 2'd2,
    SEQ_WAIT = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    OPM_HIZ = 2'b00,
    OPM_CHG = 2'b01,
    OPM_OTG = 2'b10,
    OPM_RSV = 2'b11
  } opmode_e;
endpackage

// File: rtl/rhc_persist.sv
module rhc_persist #(
  parameter int unsigned ILIM_CYC = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic flag_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(ILIM_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(ILIM_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!armed_i || !flag_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign trip_o = armed_i && flag_i && (cnt_q == LAST);
endmodule

// File: rtl/rhc_seq.sv
module rhc_seq
  import rhc_pkg::*;
#(
  parameter int unsigned SS_CYC  = 250,
  parameter int unsigned OFF_CYC = 100000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en_i,
  input  logic    trip_i,
  output seq_st_e st_o
);
  localparam int unsigned MAXC = (SS_CYC > OFF_CYC) ? SS_CYC : OFF_CYC;
  localparam int unsigned TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] SS_LAST  = TW'(SS_CYC - 1);
  localparam logic [TW-1:0] OFF_LAST = TW'(OFF_CYC - 1);

  seq_st_e       st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = SEQ_IDLE;
    end else begin
      unique case (st_q)
        SEQ_IDLE: st_d = SEQ_SOFT;
        SEQ_SOFT: if (trip_i) st_d = SEQ_WAIT;
                  else if (cnt_q == SS_LAST) st_d = SEQ_RUN;
        SEQ_RUN:  if (trip_i) st_d = SEQ_WAIT;
        SEQ_WAIT: if (cnt_q == OFF_LAST) st_d = SEQ_SOFT;
        default:  st_d = SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (st_d != st_q) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (st_q == SEQ_SOFT || st_q == SEQ_WAIT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign st_o = st_q;

  // R10: a dropped enable request always lands in idle
  p_idle_on_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st_q == SEQ_IDLE));

  // R2: the run state is only reached after a complete soft-start window
  p_full_softstart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_RUN && $past(st_q) == SEQ_SOFT) |-> ($past(cnt_q) == SS_LAST));

  // R4: off-time ends only at its terminal count
  p_full_offtime_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_SOFT && $past(st_q) == SEQ_WAIT) |-> ($past(cnt_q) == OFF_LAST));
endmodule

// File: rtl/rhc_route.sv
module rhc_route
  import rhc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault_i,
  input  logic [1:0] mode_i,
  input  logic       ign_chg_i,
  input  logic       ign_otg_i,
  input  logic       src_ovr_i,
  input  logic       src_sel_i,
  input  logic       auto_src_i,
  output logic       chg_req_o,
  output logic       otg_req_o,
  output logic       src_vbat_o
);
  logic chg_q, chg_d, otg_q, otg_d;

  always_comb begin
    chg_d = fault_i && (opmode_e'(mode_i) == OPM_CHG) && !ign_chg_i;
    otg_d = fault_i && (opmode_e'(mode_i) == OPM_OTG) && !ign_otg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= 1'b0;
      otg_q <= 1'b0;
    end else begin
      chg_q <= chg_d;
      otg_q <= otg_d;
    end
  end

  assign chg_req_o  = chg_q;
  assign otg_req_o  = otg_q;
  assign src_vbat_o = src_ovr_i ? src_sel_i : auto_src_i;

  // R5: never both supervisors at once
  p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_req_o && otg_req_o));

  // R5: high-impedance mode stays quiet
  p_hiz_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |=> (!chg_req_o && !otg_req_o));

  // R6: ignore bit of the active mode suppresses the request
  p_ign_chg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && ign_chg_i) |=> !chg_req_o);
  p_ign_otg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && ign_otg_i) |=> !otg_req_o);
endmodule

// File: rtl/reg_hiccup_ctrl.sv
module reg_hiccup_ctrl
  import rhc_pkg::*;
#(
  parameter int unsigned ILIM_CYC = 90,
  parameter int unsigned SS_CYC   = 250,
  parameter int unsigned OFF_CYC  = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic       ilim_i,
  input  logic       uv_i,
  input  logic       ovl_i,
  input  logic       sticky_clr_i,
  input  logic [1:0] mode_i,
  input  logic       ign_chg_i,
  input  logic       ign_otg_i,
  input  logic       src_ovr_i,
  input  logic       src_sel_i,
  input  logic       auto_src_i,
  output logic       reg_en_o,
  output logic       softstart_o,
  output logic       hiccup_wait_o,
  output logic       fault_sticky_o,
  output logic       chg_fault_req_o,
  output logic       otg_rst_req_o,
  output logic       sw_stop_o,
  output logic       src_vbat_o
);
  seq_st_e st;
  logic    trip;
  logic    fault_now;
  logic    sticky_q, sticky_d;

  rhc_persist #(.ILIM_CYC(ILIM_CYC)) u_persist (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed_i (reg_en_o),
    .flag_i  (ilim_i),
    .trip_o  (trip)
  );

  rhc_seq #(.SS_CYC(SS_CYC), .OFF_CYC(OFF_CYC)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (enable_i),
    .trip_i (trip),
    .st_o   (st)
  );

  assign reg_en_o      = (st == SEQ_SOFT) || (st == SEQ_RUN);
  assign softstart_o   = (st == SEQ_SOFT);
  assign hiccup_wait_o = (st == SEQ_WAIT);

  // undervoltage is expected while ramping, so it qualifies only in run
  assign fault_now = hiccup_wait_o || (uv_i && st == SEQ_RUN);

  rhc_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_i    (fault_now),
    .mode_i     (mode_i),
    .ign_chg_i  (ign_chg_i),
    .ign_otg_i  (ign_otg_i),
    .src_ovr_i  (src_ovr_i),
    .src_sel_i  (src_sel_i),
    .auto_src_i (auto_src_i),
    .chg_req_o  (chg_fault_req_o),
    .otg_req_o  (otg_rst_req_o),
    .src_vbat_o (src_vbat_o)
  );

  assign sw_stop_o = chg_fault_req_o || otg_rst_req_o;

  // set wins over clear so an active fault keeps the bit high
  always_comb begin
    sticky_d = sticky_q;
    if (ovl_i || hiccup_wait_o) sticky_d = 1'b1;
    else if (sticky_clr_i)      sticky_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= sticky_d;
  end

  assign fault_sticky_o = sticky_q;

  // R3: a qualified current limit forces the off-time
  p_trip_to_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && enable_i) |=> hiccup_wait_o);

  // R8: overload always lands in the sticky bit
  p_ovl_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_i |=> fault_sticky_o);

  // R8: without a clear the sticky bit never drops
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_sticky_o && !sticky_clr_i) |=> fault_sticky_o);
endmodule

// File: tb/sim_reg_hiccup_ctrl.sv
module sim_reg_hiccup_ctrl;
  localparam int ILIM = 6;
  localparam int SS   = 10;
  localparam int OFF  = 30;

  logic clk = 1'b0;
  logic rst_n;
  logic enable_i, ilim_i, uv_i, ovl_i, sticky_clr_i;
  logic [1:0] mode_i;
  logic ign_chg_i, ign_otg_i, src_ovr_i, src_sel_i, auto_src_i;
  logic reg_en_o, softstart_o, hiccup_wait_o, fault_sticky_o;
  logic chg_fault_req_o, otg_rst_req_o, sw_stop_o, src_vbat_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  reg_hiccup_ctrl #(.ILIM_CYC(ILIM), .SS_CYC(SS), .OFF_CYC(OFF)) u0 (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .ilim_i(ilim_i),
    .uv_i(uv_i), .ovl_i(ovl_i), .sticky_clr_i(sticky_clr_i), .mode_i(mode_i),
    .ign_chg_i(ign_chg_i), .ign_otg_i(ign_otg_i), .src_ovr_i(src_ovr_i),
    .src_sel_i(src_sel_i), .auto_src_i(auto_src_i), .reg_en_o(reg_en_o),
    .softstart_o(softstart_o), .hiccup_wait_o(hiccup_wait_o),
    .fault_sticky_o(fault_sticky_o), .chg_fault_req_o(chg_fault_req_o),
    .otg_rst_req_o(otg_rst_req_o), .sw_stop_o(sw_stop_o), .src_vbat_o(src_vbat_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_run();
    for (int i = 0; i < 500; i++) begin
      if (reg_en_o && !softstart_o && !hiccup_wait_o) break;
      step();
    end
  endtask

  // holds ilim until the trip edge, leaves ilim high
  task automatic trip_now(input string req);
    ilim_i = 1'b1;
    repeat (ILIM - 1) step();
    chk(req, "wait before final edge", hiccup_wait_o, 0);
    step();
    chk(req, "wait after trip", hiccup_wait_o, 1);
    chk(req, "reg_en after trip", reg_en_o, 0);
  endtask

  task automatic t_reset();
    chk("R1", "reg_en", reg_en_o, 0);
    chk("R1", "softstart", softstart_o, 0);
    chk("R1", "wait", hiccup_wait_o, 0);
    chk("R1", "sticky", fault_sticky_o, 0);
    chk("R1", "requests", {chg_fault_req_o, otg_rst_req_o, sw_stop_o}, 0);
  endtask

  task automatic t_softstart();
    int n;
    enable_i = 1'b1;
    step();
    chk("R2", "reg_en on entry", reg_en_o, 1);
    chk("R2", "softstart on entry", softstart_o, 1);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      if (!softstart_o) break;
      n++;
      step();
    end
    chk("R2", "softstart width", n, SS);
    chk("R2", "reg_en after softstart", reg_en_o, 1);
  endtask

  task automatic t_burst();
    int seen = 0;
    ilim_i = 1'b1;
    repeat (ILIM - 1) step();
    ilim_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (hiccup_wait_o) seen = 1;
    end
    chk("R3", "short burst trip", seen, 0);
    ilim_i = 1'b1;
    repeat (ILIM - 1) step();
    ilim_i = 1'b0;
    step();
    chk("R3", "split bursts trip", hiccup_wait_o, 0);
  endtask

  task automatic t_hiccup();
    int n;
    mode_i = 2'b00;
    trip_now("R3");
    n = 0;
    for (int i = 0; i < 200; i++) begin
      if (!hiccup_wait_o) break;
      n++;
      step();
    end
    chk("R4", "off-time width", n, OFF);
    chk("R4", "restart softstart", softstart_o, 1);
    repeat (ILIM - 1) step();
    chk("R4", "retry before trip", hiccup_wait_o, 0);
    step();
    chk("R4", "retry trips again", hiccup_wait_o, 1);
    ilim_i = 1'b0;
    go_run();
    chk("R4", "recovers to run", reg_en_o, 1);
  endtask

  task automatic t_route();
    mode_i = 2'b01;
    trip_now("R5");
    ilim_i = 1'b0;
    step();
    chk("R5", "charge request", chg_fault_req_o, 1);
    chk("R5", "no otg request in charge", otg_rst_req_o, 0);
    chk("R5", "switch stop", sw_stop_o, 1);
    go_run();
    step();
    chk("R5", "charge request released", chg_fault_req_o, 0);
    mode_i = 2'b10;
    trip_now("R5");
    ilim_i = 1'b0;
    step();
    chk("R5", "otg request", otg_rst_req_o, 1);
    chk("R5", "no charge request in otg", chg_fault_req_o, 0);
    go_run();
    mode_i = 2'b00;
    uv_i = 1'b1;
    step(); step();
    chk("R5", "hiz quiet", {chg_fault_req_o, otg_rst_req_o, sw_stop_o}, 0);
    uv_i = 1'b0;
  endtask

  task automatic t_ignore();
    mode_i = 2'b01;
    ign_chg_i = 1'b1;
    trip_now("R6");
    ilim_i = 1'b0;
    step();
    chk("R6", "ignored trip request", chg_fault_req_o, 0);
    chk("R6", "hiccup continues", hiccup_wait_o, 1);
    go_run();
    uv_i = 1'b1;
    step(); step();
    chk("R6", "ignored uv request", sw_stop_o, 0);
    uv_i = 1'b0;
    ign_chg_i = 1'b0;
    ign_otg_i = 1'b1;
    step();
    uv_i = 1'b1;
    step();
    chk("R6", "other-mode ignore no effect", chg_fault_req_o, 1);
    uv_i = 1'b0;
    ign_otg_i = 1'b0;
    step();
  endtask

  task automatic t_uv();
    mode_i = 2'b10;
    go_run();
    uv_i = 1'b1;
    step();
    chk("R7", "uv in run", otg_rst_req_o, 1);
    uv_i = 1'b0;
    step();
    chk("R7", "uv released", otg_rst_req_o, 0);
    enable_i = 1'b0;
    step();
    enable_i = 1'b1;
    step();
    uv_i = 1'b1;
    step(); step();
    chk("R7", "still in softstart", softstart_o, 1);
    chk("R7", "uv during softstart", otg_rst_req_o, 0);
    uv_i = 1'b0;
    go_run();
  endtask

  task automatic t_sticky();
    sticky_clr_i = 1'b1;
    step();
    sticky_clr_i = 1'b0;
    chk("R8", "cleared", fault_sticky_o, 0);
    ovl_i = 1'b1;
    step();
    chk("R8", "overload sets", fault_sticky_o, 1);
    sticky_clr_i = 1'b1;
    step();
    chk("R8", "clear during overload", fault_sticky_o, 1);
    sticky_clr_i = 1'b0;
    ovl_i = 1'b0;
    repeat (3) step();
    chk("R8", "holds after overload", fault_sticky_o, 1);
    sticky_clr_i = 1'b1;
    step();
    sticky_clr_i = 1'b0;
    chk("R8", "clear after overload", fault_sticky_o, 0);
  endtask

  task automatic t_source();
    for (int k = 0; k < 8; k++) begin
      src_ovr_i  = k[2];
      src_sel_i  = k[1];
      auto_src_i = k[0];
      #1;
      chk("R9", "source select", src_vbat_o, k[2] ? int'(k[1]) : int'(k[0]));
    end
  endtask

  task automatic t_disable();
    mode_i = 2'b00;
    trip_now("R10");
    ilim_i = 1'b0;
    enable_i = 1'b0;
    step();
    chk("R10", "flags idle", {reg_en_o, softstart_o, hiccup_wait_o}, 0);
    enable_i = 1'b1;
    step();
    chk("R10", "restart softstart", softstart_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    enable_i = 0; ilim_i = 0; uv_i = 0; ovl_i = 0; sticky_clr_i = 0;
    mode_i = 2'b00; ign_chg_i = 0; ign_otg_i = 0;
    src_ovr_i = 0; src_sel_i = 0; auto_src_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_softstart();
    t_burst();
    t_hiccup();
    t_route();
    t_ignore();
    t_uv();
    t_sticky();
    t_source();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule